// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, within the same cycle, whether one memory access may proceed. It receives the kind of access (load, store or instruction fetch), the starting byte address, the access length in bytes and the current privilege level. It also receives the contents of a bank of protection entries, each made of an address register and a configuration byte. An entry covers a region of memory in one of three ways: the span between the previous entry's top and its own top, a single aligned 4-byte word, or an aligned power-of-two block encoded in the trailing ones of its address register. The block produces a single allow signal that the surrounding pipeline uses to raise an access fault.

The access is probed at its start address and at every further 4-byte step that still lies inside its length. The lowest-numbered active entry that covers any probe decides the outcome. If that entry covers only some of the probes, the access is refused. Machine mode bypasses entries whose lock bit is clear, and it alone is allowed when no entry covers the access.

Top module: `pmp_check_unit`

## Requirements
- R1: Entry i takes its configuration from bits 8i+7 down to 8i of the packed configuration input. Inside that byte, bit 0 grants loads, bit 1 grants stores, bit 2 grants fetches, bits 4:3 give the matching mode and bit 7 is the lock bit. Entry i's address register is bits (PA_W-2)(i+1)-1 down to (PA_W-2)i of the address input and holds a byte address divided by 4.
- R2: An entry whose mode field is 0 never matches, whatever its permission bits and address register hold.
- R3: In mode 1 an entry covers the byte addresses from 4 times the previous entry's register up to, but not including, 4 times its own register. For entry 0 the lower bound is 0.
- R4: In mode 2 an entry covers exactly the four bytes starting at 4 times its register.
- R5: In mode 3 an entry whose register ends in k one bits covers 2^(k+3) bytes, aligned to that size, that contain 4 times the register.
- R6: The address is probed at acc_addr_i + 4j for every j with 4j less than acc_len_i; bytes between the probes are not examined separately.
- R7: When the deciding entry covers some probes of the access but not all of them, the access is refused.
- R8: Among entries that cover at least one probe, only the lowest-numbered one decides the result.
- R9: Access kind code 0 is a load, 1 a store and 2 a fetch; outside the machine-mode bypass, the deciding entry allows the access exactly when its permission bit for that kind is set, and kind code 3 is never granted by a permission bit.
- R10: At privilege code 3 (machine), a deciding entry with its lock bit clear allows the access of any kind; with the lock bit set, R9 applies to machine mode too.
- R11: When no entry covers any probe, the access is allowed exactly when the privilege code is 3; codes 0 (user) and 1 (supervisor) are refused.
- R12: The allow output depends on the present inputs only and follows a change of them within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| acc_addr_i | input | PA_W | Byte address of the access |
| acc_len_i | input | LEN_W | Access length in bytes, 1 to MAX_LEN |
| priv_i | input | 2 | Privilege code: 0 user, 1 supervisor, 3 machine |
| pmp_addr_i | input | NENT*(PA_W-2) | Packed entry address registers, entry 0 in the low bits |
| pmp_cfg_i | input | NENT*8 | Packed entry configuration bytes, entry 0 in the low byte |
| allow_o | output | 1 | 1 when the access may proceed |

## Verification
The checker watches, whenever any input moves, that at most one entry is selected, that an entry is selected exactly when some entry covers a probe, that a partly covered decision never allows, that the no-match result follows the privilege, and that machine mode passes through an unlocked covering entry. Which region an entry actually covers in each mode, the placement of the configuration byte, the probe spacing and the priority order between overlapping entries can only be shown by the bench, which sweeps every byte address of a populated window with every length, kind and privilege against an arithmetic model of the regions.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

   // access kind codes
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_EXEC  = 2'd2
   } acc_kind_e;

   // region matching modes (field decoded by the region matcher)
   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_TOR   = 2'd1,
      MODE_NA4   = 2'd2,
      MODE_NAPOT = 2'd3
   } amode_e;

   localparam logic [1:0] PRIV_MACHINE = 2'd3;

   // configuration byte, bit 7 down to bit 0
   typedef struct packed {
      logic       lock;
      logic [1:0] rsv;
      amode_e     mode;
      logic       ex;
      logic       wr;
      logic       rd;
   } cfg_t;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
   import pmp_chk_pkg::*;
#(
   parameter int PA_W  = 34,
   parameter int NSTEP = 2,
   localparam int AR_W = PA_W - 2
)(
   input  amode_e                  mode_i,
   input  logic [AR_W-1:0]         top_reg_i,
   input  logic [PA_W-1:0]         lo_i,
   input  logic [NSTEP*PA_W-1:0]   step_addr_i,
   input  logic [NSTEP-1:0]        step_en_i,
   output logic                    any_hit_o,
   output logic                    all_hit_o
);

   logic [PA_W-1:0]  top;
   logic [PA_W-1:0]  ext;
   logic [PA_W-1:0]  ones;
   logic [PA_W-1:0]  nmask;
   logic [NSTEP-1:0] hit;

   assign top   = {top_reg_i, 2'b00};
   // low bit forced to one except for the single-word mode
   assign ext   = {1'b0, top_reg_i, (mode_i != MODE_NA4)};
   // isolate the run of trailing ones
   assign ones  = ext & ~(ext + PA_W'(1));
   assign nmask = (~ones) << 2;

   for (genvar k = 0; k < NSTEP; k++) begin : g_probe
      logic [PA_W-1:0] a;
      assign a = step_addr_i[k*PA_W +: PA_W];
      assign hit[k] = (mode_i == MODE_TOR) ? ((a >= lo_i) && (a < top))
                                           : (((a ^ top) & nmask) == '0);
   end

   assign any_hit_o = (mode_i != MODE_OFF) && (|(hit & step_en_i));
   assign all_hit_o = &(hit | ~step_en_i);

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
   import pmp_chk_pkg::*;
(
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic       ex_i,
   input  logic       lock_i,
   input  logic [1:0] kind_i,
   input  logic [1:0] priv_i,
   output logic       grant_o
);

   logic kind_ok;

   always_comb begin
      case (kind_i)
         ACC_LOAD:  kind_ok = rd_i;
         ACC_STORE: kind_ok = wr_i;
         ACC_EXEC:  kind_ok = ex_i;
         default:   kind_ok = 1'b0;
      endcase
      grant_o = ((priv_i == PRIV_MACHINE) && !lock_i) || kind_ok;
   end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
   parameter int N = 16
)(
   input  logic [N-1:0] hit_i,
   output logic [N-1:0] sel_o,
   output logic         found_o
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign sel_o[i]    = hit_i[i] & ~seen[i];
      assign seen[i + 1] = seen[i] | hit_i[i];
   end
   assign found_o = seen[N];

endmodule

// File: rtl/pmp_check_unit.sv
module pmp_check_unit
   import pmp_chk_pkg::*;
#(
   parameter int NENT    = 16,
   parameter int PA_W    = 34,
   parameter int MAX_LEN = 8,
   localparam int AR_W   = PA_W - 2,
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
)(
   input  logic [1:0]           acc_kind_i,
   input  logic [PA_W-1:0]      acc_addr_i,
   input  logic [LEN_W-1:0]     acc_len_i,
   input  logic [1:0]           priv_i,
   input  logic [NENT*AR_W-1:0] pmp_addr_i,
   input  logic [NENT*8-1:0]    pmp_cfg_i,
   output logic                 allow_o
);

   localparam int NSTEP = (MAX_LEN + 3) / 4;

   if (NENT < 1 || NENT > 64) begin : g_bad_nent
      $error("pmp_check_unit: NENT must be 1..64");
   end
   if (PA_W < 4 || PA_W > 64) begin : g_bad_paw
      $error("pmp_check_unit: PA_W must be 4..64");
   end
   if (MAX_LEN < 1 || MAX_LEN > 64) begin : g_bad_len
      $error("pmp_check_unit: MAX_LEN must be 1..64");
   end

   // probe addresses, one per 4-byte step of the access
   logic [NSTEP*PA_W-1:0] step_addr;
   logic [NSTEP-1:0]      step_en;

   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      assign step_addr[k*PA_W +: PA_W] = acc_addr_i + PA_W'(4 * k);
      assign step_en[k] = acc_len_i > LEN_W'(4 * k);
   end

   cfg_t              cfg [NENT];
   logic [NENT*2-1:0] cfg_unused;
   logic [NENT-1:0]   hit_any;
   logic [NENT-1:0]   hit_all;
   logic [NENT-1:0]   lock_vec;
   logic [NENT-1:0]   perm_ok;
   logic [NENT-1:0]   sel_vec;
   logic              found;

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      logic [PA_W-1:0] lo;

      assign cfg[i]                = cfg_t'(pmp_cfg_i[8*i +: 8]);
      assign cfg_unused[2*i +: 2]  = cfg[i].rsv;
      assign lock_vec[i]           = cfg[i].lock;

      if (i == 0) begin : g_first
         assign lo = '0;
      end else begin : g_rest
         assign lo = {pmp_addr_i[AR_W*(i-1) +: AR_W], 2'b00};
      end

      pmp_region_match #(
         .PA_W  (PA_W),
         .NSTEP (NSTEP)
      ) u_match (
         .mode_i      (cfg[i].mode),
         .top_reg_i   (pmp_addr_i[AR_W*i +: AR_W]),
         .lo_i        (lo),
         .step_addr_i (step_addr),
         .step_en_i   (step_en),
         .any_hit_o   (hit_any[i]),
         .all_hit_o   (hit_all[i])
      );

      pmp_perm_eval u_perm (
         .rd_i    (cfg[i].rd),
         .wr_i    (cfg[i].wr),
         .ex_i    (cfg[i].ex),
         .lock_i  (cfg[i].lock),
         .kind_i  (acc_kind_i),
         .priv_i  (priv_i),
         .grant_o (perm_ok[i])
      );
   end

   pmp_first_hit #(
      .N (NENT)
   ) u_prio (
      .hit_i   (hit_any),
      .sel_o   (sel_vec),
      .found_o (found)
   );

   assign allow_o = found ? (|(sel_vec & hit_all & perm_ok))
                          : (priv_i == PRIV_MACHINE);

endmodule

// File: rtl/pmp_check_unit_sva.sv
module pmp_check_unit_sva #(
   parameter int NENT = 16
)(
   input logic [1:0]      priv_i,
   input logic            allow_o,
   input logic [NENT-1:0] hit_any,
   input logic [NENT-1:0] hit_all,
   input logic [NENT-1:0] sel_vec,
   input logic [NENT-1:0] lock_vec,
   input logic            found
);

   always_comb begin
      // R8
      sel_onehot_chk: assert ($onehot0(sel_vec))
         else $error("more than one deciding entry");
      // R8
      found_chk: assert (found == (|hit_any))
         else $error("selection disagrees with entry hits");
      // R11
      if (!found) begin
         nomatch_chk: assert (allow_o == (priv_i == 2'd3))
            else $error("no-match result ignores privilege");
      end
      // R7
      if (|(sel_vec & ~hit_all)) begin
         partial_chk: assert (!allow_o)
            else $error("partly covered access allowed");
      end
      // R10
      if ((priv_i == 2'd3) && (|(sel_vec & hit_all & ~lock_vec))) begin
         mach_bypass_chk: assert (allow_o)
            else $error("machine access refused by unlocked entry");
      end
   end

endmodule

bind pmp_check_unit pmp_check_unit_sva #(
   .NENT (NENT)
) u_sva (
   .priv_i   (priv_i),
   .allow_o  (allow_o),
   .hit_any  (hit_any),
   .hit_all  (hit_all),
   .sel_vec  (sel_vec),
   .lock_vec (lock_vec),
   .found    (found)
);

// File: tb/pmp_check_unit_test.sv
`timescale 1ns/1ps
module pmp_check_unit_test;

   localparam int NENT  = 16;
   localparam int PA_W  = 34;
   localparam int AR_W  = PA_W - 2;
   localparam int LEN_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0]           acc_kind = '0;
   logic [PA_W-1:0]      acc_addr = '0;
   logic [LEN_W-1:0]     acc_len  = 4'd4;
   logic [1:0]           priv     = '0;
   logic [NENT*AR_W-1:0] pmp_addr = '0;
   logic [NENT*8-1:0]    pmp_cfg  = '0;
   logic                 allow;

   pmp_check_unit uut (
      .acc_kind_i (acc_kind),
      .acc_addr_i (acc_addr),
      .acc_len_i  (acc_len),
      .priv_i     (priv),
      .pmp_addr_i (pmp_addr),
      .pmp_cfg_i  (pmp_cfg),
      .allow_o    (allow)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [7:0]      cfgb [NENT];
   logic [AR_W-1:0] regs [NENT];

   task automatic clear_cfg();
      for (int i = 0; i < NENT; i++) begin
         cfgb[i] = '0;
         regs[i] = '0;
      end
   endtask

   task automatic load_cfg();
      @(posedge clk);
      for (int i = 0; i < NENT; i++) begin
         pmp_cfg[8*i +: 8]     = cfgb[i];
         pmp_addr[AR_W*i +: AR_W] = regs[i];
      end
   endtask

   // arithmetic region model
   function automatic bit region_hit(int i, longint a);
      longint r;
      longint lo;
      longint sz;
      longint base;
      int     k;
      r = longint'({32'b0, regs[i]});
      case (cfgb[i][4:3])
         2'd1: begin
            lo = (i == 0) ? 0 : longint'({32'b0, regs[i-1]}) * 4;
            return (a >= lo) && (a < r * 4);
         end
         2'd2: return (a >= r * 4) && (a < r * 4 + 4);
         2'd3: begin
            k = 0;
            while (((r >> k) & 1) == 1) k++;
            sz   = longint'(1) << (k + 3);
            base = (r * 4) & ~(sz - 1);
            return (a >= base) && (a < base + sz);
         end
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit model(longint addr, int len, int kind, int prv, output string tag);
      bit any;
      bit all;
      bit h;
      for (int i = 0; i < NENT; i++) begin
         if (cfgb[i][4:3] != 2'd0) begin
            any = 0;
            all = 1;
            for (int off = 0; off < len; off += 4) begin
               h = region_hit(i, addr + off);
               any |= h;
               all &= h;
            end
            if (any) begin
               if (!all) begin
                  tag = "R7";
                  return 1'b0;
               end
               if (prv == 3 && !cfgb[i][7]) begin
                  tag = "R10";
                  return 1'b1;
               end
               tag = "R9";
               return (kind < 3) ? cfgb[i][kind] : 1'b0;
            end
         end
      end
      tag = "R11";
      return prv == 3;
   endfunction

   task automatic judge(bit act, bit exp, string tag, longint addr, int len, int kind, int prv);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s addr=%h len=%0d kind=%0d priv=%0d actual=%b expected=%b",
                  tag, addr, len, kind, prv, act, exp);
      end
   endtask

   // want < 0: expected from the model; otherwise hand value
   task automatic probe(longint addr, int len, int kind, int prv, int want, string tag);
      bit    exp;
      string mtag;
      @(posedge clk);
      #0.5;
      acc_addr = addr[PA_W-1:0];
      acc_len  = len[LEN_W-1:0];
      acc_kind = kind[1:0];
      priv     = prv[1:0];
      exp = model(addr, len, kind, prv, mtag);
      if (want >= 0) exp = want[0];
      if (tag == "") tag = mtag;
      @(negedge clk);
      judge(allow, exp, tag, addr, len, kind, prv);
   endtask

   task automatic sweep(longint hi);
      int lens [4] = '{1, 2, 4, 8};
      for (longint a = 0; a < hi; a++) begin
         for (int li = 0; li < 4; li++) begin
            for (int kd = 0; kd < 3; kd++) begin
               for (int pi = 0; pi < 2; pi++) begin
                  probe(a, lens[li], kd, pi ? 3 : (a[0] ? 1 : 0), -1, "");
               end
            end
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R12 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      clear_cfg();
      repeat (4) @(posedge clk);
      rst_n = 1'b1;

      // empty bank after reset: R11
      probe(64'h40, 4, 0, 0, 0, "R11");
      probe(64'h40, 4, 1, 1, 0, "R11");
      probe(64'h40, 4, 2, 3, 1, "R11");

      // scenario A
      clear_cfg();
      regs[0] = 32'h40;  cfgb[0] = 8'h07;  // off, all permissions
      regs[1] = 32'h80;  cfgb[1] = 8'h09;  // TOR 0x100..0x1ff, load
      regs[2] = 32'h90;  cfgb[2] = 8'h12;  // NA4 0x240, store
      regs[3] = 32'hC7;  cfgb[3] = 8'h9C;  // NAPOT 0x300 64B, fetch, locked
      regs[4] = 32'hDF;  cfgb[4] = 8'h1F;  // NAPOT 0x300 256B, all
      regs[5] = 32'h140; cfgb[5] = 8'h8B;  // TOR 0x37c..0x4ff, load/store, locked
      load_cfg();

      probe(64'h10,  4, 0, 0, 0, "R2");
      probe(64'h100, 4, 0, 0, 1, "R3");
      probe(64'h0FC, 4, 0, 0, 0, "R3");
      probe(64'h1FC, 4, 0, 0, 1, "R3");
      probe(64'h200, 4, 0, 0, 0, "R3");
      probe(64'h240, 4, 1, 0, 1, "R4");
      probe(64'h244, 4, 1, 0, 0, "R4");
      probe(64'h23C, 4, 1, 0, 0, "R4");
      probe(64'h33C, 4, 2, 0, 1, "R5");
      probe(64'h340, 4, 2, 0, 1, "R5");
      probe(64'h340, 4, 1, 0, 1, "R5");
      probe(64'h3FC, 4, 0, 0, 1, "R5");
      probe(64'h1F8, 5, 0, 0, 1, "R6");
      probe(64'h1FE, 4, 0, 0, 1, "R6");
      probe(64'h1FC, 5, 0, 0, 0, "R6");
      probe(64'h1FC, 8, 0, 0, 0, "R7");
      probe(64'h23C, 8, 1, 0, 0, "R7");
      probe(64'h310, 4, 0, 0, 0, "R8");
      probe(64'h310, 4, 0, 3, 0, "R8");
      probe(64'h310, 4, 2, 3, 1, "R10");
      probe(64'h100, 4, 1, 3, 1, "R10");
      probe(64'h100, 4, 1, 0, 0, "R9");
      probe(64'h100, 4, 3, 0, 0, "R9");
      probe(64'h480, 4, 2, 3, 0, "R10");
      probe(64'h480, 4, 1, 3, 1, "R9");

      // R12: output follows inputs inside one cycle
      @(posedge clk);
      #0.5;
      acc_addr = 34'h100; acc_len = 4'd4; acc_kind = 2'd0; priv = 2'd0;
      #0.5;
      judge(allow, 1'b1, "R12", 64'h100, 4, 0, 0);
      acc_addr = 34'h0FC;
      #0.5;
      judge(allow, 1'b0, "R12", 64'h0FC, 4, 0, 0);

      sweep(64'h600);

      // scenario B: high entries
      clear_cfg();
      regs[7]  = 32'h20;  cfgb[7]  = 8'h91;  // NA4 0x80, load, locked
      regs[13] = 32'h100; cfgb[13] = 8'h00;  // off, gives TOR base 0x400
      regs[14] = 32'h120; cfgb[14] = 8'h0C;  // TOR 0x400..0x47f, fetch
      regs[15] = 32'h13F; cfgb[15] = 8'h1B;  // NAPOT 0x400 512B, load/store
      load_cfg();

      probe(64'h5F0, 4, 0, 0, 1, "R1");
      probe(64'h5F0, 4, 2, 0, 0, "R1");
      probe(64'h80,  4, 0, 3, 1, "R1");
      probe(64'h80,  4, 1, 3, 0, "R10");
      probe(64'h410, 4, 2, 0, 1, "R8");
      probe(64'h410, 4, 0, 0, 0, "R8");
      probe(64'h47C, 8, 0, 0, 0, "R7");
      probe(64'h3FC, 4, 0, 1, 0, "R11");

      sweep(64'h600);

      finish_run();
   end

endmodule